// File: doc/BRIEF.md
# UART Receive FIFO with Character Timeout

This block is the receive-side holding buffer of a 16550-class serial port. Bytes finished by the receive shift register come in through a valid/ready stream port. They are stored in a 16-entry first-in first-out queue. The CPU takes bytes out one at a time with a read strobe, and each byte appears on a registered data output.

The block raises two interrupt requests. The data-available request is raised while the fill level is at or above a trigger threshold that software selects. The character-timeout request covers the tail of a message that never reaches the threshold. It is raised when bytes have been sitting in the queue for a set number of character times with no read and no new arrival.

A byte that arrives while the queue is full is dropped and sets a sticky overrun flag. A line-status read strobe clears that flag. The shift register cannot stall, so `rx_ready` is advisory only. Whenever `rx_valid` is high, a byte is presented for exactly that cycle. It is taken if `rx_ready` is high and lost (with overrun) if it is low. There is no back-pressure beyond that.

Top module: `uart_rx_fifo_ctl`

## Requirements
- R1: The queue holds at most 16 bytes. `fill_level` never exceeds 16, and `rx_ready` is low exactly while 16 bytes are held.
- R2: `lvl_sel` selects the data threshold: 00 = 1 byte, 01 = 4, 10 = 8, 11 = 14. `irq_data` is high while `rx_irq_en` is high and `fill_level` is at or above the threshold. It is combinational from the level, so it changes in the same cycle the level changes.
- R3: A byte offered while the queue is full is not stored. The level stays at 16 and the stored bytes and their order are unchanged.
- R4: `overrun` is set on the clock after a byte is offered while the queue is full. It stays set until a cycle with `lsr_rd` high. If a new overrun occurs in the same cycle as `lsr_rd`, the flag stays set.
- R5: `irq_timeout` rises after the 4th `char_tick` pulse while the queue is non-empty and untouched, counting from the most recent push or pop. It is visible on the clock edge that samples that tick.
- R6: A successful pop or a successful push restarts the timeout count and drops `irq_timeout` on the following clock.
- R7: `char_tick` pulses while the queue is empty do not advance the timeout, and `irq_timeout` is never high with an empty queue.
- R8: `rd_en` with an empty queue leaves `rd_data` unchanged and leaves `fill_level` at 0.
- R9: Bytes leave in arrival order. `rd_data` takes the head byte on the clock edge that samples `rd_en`, and it reads 0 after reset.
- R10: With `rx_irq_en` low, both `irq_data` and `irq_timeout` are low. Storage, level and timeout counting are unaffected.
- R11: After reset the queue is empty (`fill_level` 0, `data_avail` 0), `rx_ready` is 1, and `overrun`, `irq_data` and `irq_timeout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Shift register offers a completed byte this cycle |
| rx_data | input | 8 | Byte offered by the shift register |
| rx_ready | output | 1 | Queue has room; low while full |
| rd_en | input | 1 | CPU read strobe, one pop per cycle |
| rd_data | output | 8 | Last byte popped (registered) |
| data_avail | output | 1 | Queue is non-empty |
| fill_level | output | 5 | Number of bytes held (0..16) |
| lvl_sel | input | 2 | Data-interrupt threshold select |
| rx_irq_en | input | 1 | Receive interrupt enable |
| char_tick | input | 1 | One pulse per character time |
| lsr_rd | input | 1 | Line-status read strobe; clears overrun |
| overrun | output | 1 | Sticky overrun flag |
| irq_data | output | 1 | Data-available interrupt request |
| irq_timeout | output | 1 | Character-timeout interrupt request |

## Verification
The threshold logic is tried with each of the four select codes. The queue is filled to one below the threshold and then one more byte is added, which shows an off-by-one compare and a swapped code apart from a correct decode. A scripted sequence of interleaved pushes and pops shows ordering and pointer-wrap mistakes through the returned data. Filling to capacity and then offering more bytes, with and without a same-cycle status read, separates the drop rule from the flag set/clear priority. For the timeout, ticks are given with the queue empty, then three and four ticks with a byte held, followed by a push and a pop. This separates the count threshold, the empty-queue gating and both restart causes.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  typedef enum logic [1:0] {
    TRIG_ONE     = 2'b00,
    TRIG_QUARTER = 2'b01,
    TRIG_HALF    = 2'b10,
    TRIG_HIGH    = 2'b11
  } trig_sel_e;

  // Threshold in bytes for a given select code and queue depth.
  function automatic int unsigned trig_bytes(input logic [1:0] sel, input int unsigned depth);
    int unsigned r;
    case (trig_sel_e'(sel))
      TRIG_ONE:     r = 1;
      TRIG_QUARTER: r = depth / 4;
      TRIG_HALF:    r = depth / 2;
      default:      r = depth - 2;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty
);

  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     count_q;
  logic [DATA_W-1:0] slot_q [DEPTH];

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // One register row per entry; only the addressed row loads.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (wr_ptr_q == AW'(g))) slot_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push, pop})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_data = slot_q[rd_ptr_q];
  assign count     = count_q;
  assign full      = (count_q == CW'(DEPTH));
  assign empty     = (count_q == '0);

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int LIMIT = 4,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic touch,
  input  logic nonempty,
  input  logic tick,
  output logic expired
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (touch || !nonempty) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != TW'(LIMIT))) begin
      cnt_q <= cnt_q + TW'(1);
    end
  end

  assign expired = (cnt_q == TW'(LIMIT));

endmodule

// File: rtl/rxq_irq_gen.sv
module rxq_irq_gen
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count,
  input  logic [1:0]    lvl_sel,
  input  logic          irq_en,
  input  logic          idle_expired,
  input  logic          nonempty,
  output logic          irq_data,
  output logic          irq_timeout
);

  logic [CW-1:0] thresh;

  always_comb begin
    thresh      = CW'(trig_bytes(lvl_sel, DEPTH));
    irq_data    = irq_en && (count >= thresh);
    irq_timeout = irq_en && nonempty && idle_expired;
  end

endmodule

// File: rtl/uart_rx_fifo_ctl.sv
module uart_rx_fifo_ctl #(
  parameter int DATA_W       = 8,
  parameter int DEPTH        = 16,
  parameter int TIMEOUT_CHAR = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              data_avail,
  output logic [CW-1:0]     fill_level,
  input  logic [1:0]        lvl_sel,
  input  logic              rx_irq_en,
  input  logic              char_tick,
  input  logic              lsr_rd,
  output logic              overrun,
  output logic              irq_data,
  output logic              irq_timeout
);

  logic              push, pop, full, empty, idle_expired;
  logic [DATA_W-1:0] head_data;
  logic [DATA_W-1:0] rd_data_q;
  logic              overrun_q;

  assign push = rx_valid && !full;
  assign pop  = rd_en && !empty;

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .wr_data   (rx_data),
    .pop       (pop),
    .head_data (head_data),
    .count     (fill_level),
    .full      (full),
    .empty     (empty)
  );

  rxq_idle_timer #(.LIMIT(TIMEOUT_CHAR)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .touch    (push || pop),
    .nonempty (!empty),
    .tick     (char_tick),
    .expired  (idle_expired)
  );

  rxq_irq_gen #(.DEPTH(DEPTH)) irq_i (
    .count        (fill_level),
    .lvl_sel      (lvl_sel),
    .irq_en       (rx_irq_en),
    .idle_expired (idle_expired),
    .nonempty     (!empty),
    .irq_data     (irq_data),
    .irq_timeout  (irq_timeout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
      overrun_q <= 1'b0;
    end else begin
      if (pop) rd_data_q <= head_data;
      if (rx_valid && full) overrun_q <= 1'b1;
      else if (lsr_rd)      overrun_q <= 1'b0;
    end
  end

  assign rx_ready   = !full;
  assign data_avail = !empty;
  assign rd_data    = rd_data_q;
  assign overrun    = overrun_q;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker
  import uart_rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              data_avail,
  input logic [CW-1:0]     fill_level,
  input logic [1:0]        lvl_sel,
  input logic              rx_irq_en,
  input logic              lsr_rd,
  input logic              overrun,
  input logic              irq_data,
  input logic              irq_timeout
);

  logic [CW-1:0] exp_thr;
  logic          at_cap;
  assign exp_thr = CW'(trig_bytes(lvl_sel, DEPTH));
  assign at_cap  = (fill_level == CW'(DEPTH));

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) fill_level <= CW'(DEPTH)); // R1
  AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n) at_cap |-> !rx_ready); // R1
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (at_cap && !rd_en) |=> at_cap); // R3
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && at_cap) |=> overrun); // R4
  AST_OVR_CLR: assert property (@(posedge clk) disable iff (!rst_n) (lsr_rd && !(rx_valid && at_cap)) |=> !overrun); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (overrun && !lsr_rd) |=> overrun); // R4
  AST_DATA_IRQ: assert property (@(posedge clk) disable iff (!rst_n) irq_data |-> (fill_level >= exp_thr)); // R2
  AST_TO_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && data_avail) |=> !irq_timeout); // R6
  AST_TO_WRITE_CLR: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && rx_ready) |=> !irq_timeout); // R6
  AST_TO_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) irq_timeout |-> data_avail); // R7
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && !data_avail && !rx_valid) |=> ($stable(rd_data) && fill_level == '0)); // R8
  AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n) !rx_irq_en |-> (!irq_data && !irq_timeout)); // R10

endmodule

bind uart_rx_fifo_ctl rxq_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .rd_en       (rd_en),
  .rd_data     (rd_data),
  .data_avail  (data_avail),
  .fill_level  (fill_level),
  .lvl_sel     (lvl_sel),
  .rx_irq_en   (rx_irq_en),
  .lsr_rd      (lsr_rd),
  .overrun     (overrun),
  .irq_data    (irq_data),
  .irq_timeout (irq_timeout)
);

// File: tb/uart_rx_fifo_ctl_tb.sv
module uart_rx_fifo_ctl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_ready;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       data_avail;
  logic [4:0] fill_level;
  logic [1:0] lvl_sel = 2'b01;
  logic       rx_irq_en = 1'b1;
  logic       char_tick = 1'b0;
  logic       lsr_rd = 1'b0;
  logic       overrun, irq_data, irq_timeout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_rx_fifo_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .rd_en(rd_en), .rd_data(rd_data), .data_avail(data_avail), .fill_level(fill_level),
    .lvl_sel(lvl_sel), .rx_irq_en(rx_irq_en), .char_tick(char_tick), .lsr_rd(lsr_rd),
    .overrun(overrun), .irq_data(irq_data), .irq_timeout(irq_timeout)
  );

  // Vector: {op[1:0] (0 idle,1 push,2 pop), data[7:0], exp level[4:0], exp irq_data, exp rd_data[7:0]}
  localparam int NV = 11;
  localparam logic [23:0] VEC [NV] = '{
    {2'd1, 8'h11, 5'd1, 1'b0, 8'h00},
    {2'd1, 8'h22, 5'd2, 1'b0, 8'h00},
    {2'd1, 8'h33, 5'd3, 1'b0, 8'h00},
    {2'd1, 8'h44, 5'd4, 1'b1, 8'h00},
    {2'd2, 8'h00, 5'd3, 1'b0, 8'h11},
    {2'd2, 8'h00, 5'd2, 1'b0, 8'h22},
    {2'd1, 8'h55, 5'd3, 1'b0, 8'h22},
    {2'd2, 8'h00, 5'd2, 1'b0, 8'h33},
    {2'd2, 8'h00, 5'd1, 1'b0, 8'h44},
    {2'd2, 8'h00, 5'd0, 1'b0, 8'h55},
    {2'd2, 8'h00, 5'd0, 1'b0, 8'h55}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // All stimulus tasks start and end at a falling edge.
  task automatic do_push(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic do_pop();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_tick();
    char_tick = 1'b1;
    @(negedge clk);
    char_tick = 1'b0;
  endtask

  task automatic drain();
    while (data_avail) do_pop();
  endtask

  function automatic int thr_of(input int sel);
    case (sel)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(fill_level == 0 && !data_avail, "R11 level", fill_level, 0);
    chk(rx_ready && !overrun, "R11 ready/overrun", {rx_ready, overrun}, 2);
    chk(!irq_data && !irq_timeout, "R11 irqs", {irq_data, irq_timeout}, 0);
    chk(rd_data == 8'h00, "R9 rd_data after reset", rd_data, 0);

    // Vector walk, threshold 4: R2 level/irq, R9 order, R8 empty read
    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      if (v[23:22] == 2'd1) do_push(v[21:14]);
      else if (v[23:22] == 2'd2) do_pop();
      else @(negedge clk);
      chk(fill_level == v[13:9], "R9 vector level", fill_level, v[13:9]);
      chk(irq_data == v[8], "R2 vector irq_data", irq_data, v[8]);
      chk(rd_data == v[7:0], "R9/R8 vector rd_data", rd_data, v[7:0]);
    end

    // R2 each threshold code
    for (int s = 0; s < 4; s++) begin
      int t;
      lvl_sel = 2'(s);
      t = thr_of(s);
      for (int k = 0; k < t - 1; k++) do_push(8'(k));
      chk(!irq_data, "R2 below threshold", irq_data, 0);
      do_push(8'hF0);
      chk(irq_data, "R2 at threshold", irq_data, 1);
      // R10 masking
      rx_irq_en = 1'b0;
      #1;
      chk(!irq_data && fill_level == 5'(t), "R10 masked data irq", irq_data, 0);
      rx_irq_en = 1'b1;
      @(negedge clk);
      drain();
    end

    // R1/R3/R4 capacity and overrun
    lvl_sel = 2'b11;
    for (int k = 0; k < 16; k++) do_push(8'(8'h60 + k));
    chk(fill_level == 16 && !rx_ready, "R1 full", fill_level, 16);
    chk(!overrun, "R4 no overrun yet", overrun, 0);
    do_push(8'hEE);
    chk(fill_level == 16, "R3 level held", fill_level, 16);
    chk(overrun, "R4 overrun set", overrun, 1);
    @(negedge clk);
    chk(overrun, "R4 overrun sticky", overrun, 1);
    lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;
    chk(!overrun, "R4 overrun cleared", overrun, 0);
    lsr_rd = 1'b1; do_push(8'hEF); lsr_rd = 1'b0;
    chk(overrun, "R4 set wins over clear", overrun, 1);
    for (int k = 0; k < 16; k++) begin
      do_pop();
      chk(rd_data == 8'(8'h60 + k), "R3 contents kept", rd_data, 8'h60 + k);
    end
    chk(fill_level == 0, "R1 drained", fill_level, 0);
    do_pop();
    chk(rd_data == 8'h6F && fill_level == 0, "R8 empty read", rd_data, 8'h6F);
    lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;

    // R5/R6/R7 timeout
    repeat (6) do_tick();
    chk(!irq_timeout, "R7 ticks while empty", irq_timeout, 0);
    do_push(8'hA1);
    repeat (3) do_tick();
    chk(!irq_timeout, "R5 three ticks", irq_timeout, 0);
    do_tick();
    chk(irq_timeout, "R5 four ticks", irq_timeout, 1);
    do_push(8'hA2);
    chk(!irq_timeout, "R6 cleared by push", irq_timeout, 0);
    repeat (4) do_tick();
    chk(irq_timeout, "R5 re-armed", irq_timeout, 1);
    rx_irq_en = 1'b0;
    #1;
    chk(!irq_timeout, "R10 masked timeout", irq_timeout, 0);
    rx_irq_en = 1'b1;
    #1;
    chk(irq_timeout, "R10 unmask timeout", irq_timeout, 1);
    @(negedge clk);
    do_pop();
    chk(!irq_timeout && rd_data == 8'hA1, "R6 cleared by pop", irq_timeout, 0);
    repeat (4) do_tick();
    chk(irq_timeout, "R5 after pop", irq_timeout, 1);
    do_pop();
    chk(!irq_timeout && fill_level == 0, "R7 empty no timeout", irq_timeout, 0);

    finish_run();
  end

endmodule